// File: doc/BRIEF.md
# Buffered SPI Message Controller

This block is a single-master SPI controller that runs a complete message per command. Software fills a byte buffer with the outgoing data. It then writes a message word with a byte count and a message type. Finally it issues a start command that names the target device. The controller asserts that device's chip select and shifts out the bytes, MSB first, in the configured clock mode and rate. It stores the incoming bytes in a receive buffer, reports how many were kept, and raises a completion status bit. An interrupt mask gates that bit onto the `irq` pin.

Three message types are supported. Full duplex sends and stores. Half-duplex write sends and discards the incoming line. Half-duplex read drives MOSI low and stores. Words are always 8 bits. The register port is a plain synchronous write strobe with a combinational read. It has no handshake and no back-pressure: every write is taken on the clock edge where `reg_wr` is high, and a write that the block cannot use is dropped. The serial pins are plain levels.

Register map (word addresses): 0x00 mode {cpha[4], cpol[3], rate[2:0]}; 0x01 rate-only write; 0x02 message {type[9:8], count[7:0]}; 0x03 transmit push [7:0]; 0x04 command {device[9:8], prepend[7:4], opcode[3:0]}; 0x05 status {done[0]}; 0x06 mask [0]; 0x07 receive tail; 0x10+i receive byte i.

Top module: `spi_msg_ctrl`

## Requirements
- R1: After reset, all chip selects are high, `irq` is low, `sck` is low, and the mode, status and receive-tail registers all read 0.
- R2: All four clock modes work. With no message running, SCK rests at cpol. With cpha=0, data is sampled on the leading SCK edge and launched on the trailing edge. With cpha=1, data is launched on the leading edge and sampled on the trailing edge. Bytes go MSB first in both directions.
- R3: The SCK half period is BASE_HALF*2^code clock cycles for rate codes 0 to 6. Code 7 behaves as code 6, the slowest rate.
- R4: A write to the rate-only address (0x01) changes only the rate field; cpol and cpha keep their values.
- R5: Message type field [9:8] uses these codes: 0 = full duplex, 1 = half-duplex read (MOSI held at 0, bytes stored), 2 = half-duplex write (bytes sent, nothing stored), 3 = full duplex.
- R6: Each write to 0x03 appends a byte, and the i-th byte pushed is the i-th byte sent. Pushes beyond DEPTH are dropped and pushes during a message are ignored. The push position returns to 0 when a message ends, while the buffer contents are kept.
- R7: A start is accepted only if opcode [3:0] equals 1, prepend [7:4] equals 0, and the message count lies between 1 and DEPTH. Any other command leaves the block idle.
- R8: A start command issued while a message is running is ignored.
- R9: During a message, only the chip select named by command bits [9:8] is low. All chip selects are high between messages.
- R10: Status bit 0 is set when a message ends. `irq` is high exactly when that bit and mask bit 0 are both set.
- R11: Writing 0x00FF to the status register clears it. A write with any other value leaves it unchanged.
- R12: The receive-tail register gives the number of bytes stored by the last message: the count for full duplex and half-duplex read, 0 for half-duplex write. Stored byte i reads at address 0x10+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Masked message-complete interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A bad bit counter or a wrong edge-parity choice in the shifter shows up as corrupted bytes. The bench's protocol-level slave model catches this on the first byte of the first message in the affected mode, in both the slave's captured MOSI data and the receive-buffer readback. Errors in pointer and count state show up one message later: a wrong tail count, a stale or shifted transmit byte, or a chip select held past the done status. A leaked start or a status bit that fails to clear shows on `cs_n` or `irq` within a few cycles of the offending register write.

// File: rtl/spimc_pkg.sv
package spimc_pkg;
  typedef enum logic [1:0] {
    MT_FULL  = 2'd0,
    MT_READ  = 2'd1,
    MT_WRITE = 2'd2,
    MT_ALT   = 2'd3
  } msg_type_e;

  localparam logic [4:0] A_MODE   = 5'h00;
  localparam logic [4:0] A_RATE   = 5'h01;
  localparam logic [4:0] A_MSG    = 5'h02;
  localparam logic [4:0] A_TXPUSH = 5'h03;
  localparam logic [4:0] A_CMD    = 5'h04;
  localparam logic [4:0] A_ISTAT  = 5'h05;
  localparam logic [4:0] A_IMASK  = 5'h06;
  localparam logic [4:0] A_RXTAIL = 5'h07;

  localparam logic [3:0] OP_START = 4'h1;
  localparam logic [7:0] CLR_ALL  = 8'hFF;
  localparam logic [2:0] SLOWEST  = 3'd6;
endpackage

// File: rtl/spimc_bytebuf.sv
module spimc_bytebuf #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spimc_shifter.sv
module spimc_shifter
  import spimc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4,
  parameter int BASE_HALF = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [2:0]       rate,
  input  logic [CNT_W-1:0] nbytes,
  input  msg_type_e        mtype,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic [IDX_W-1:0] tx_idx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [7:0]       rx_byte,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             mosi
);
  localparam int DIV_W = $clog2((BASE_HALF << 6) + 1);

  logic             busy_q, done_q, sck_q, ph_q;
  msg_type_e        mt_q;
  logic [DIV_W-1:0] div_q, half_m1_q;
  logic [3:0]       k_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] last_q;
  logic [7:0]       txsr;
  logic [6:0]       rxsr;
  logic [2:0]       code;
  logic             tick, sample, last_byte;

  assign code      = (rate > SLOWEST) ? SLOWEST : rate;
  assign tick      = busy_q && (div_q == half_m1_q);
  assign sample    = (k_q[0] == ph_q);
  assign last_byte = (CNT_W'(idx_q) == last_q);

  assign rx_byte = {rxsr, miso};
  assign rx_idx  = idx_q;
  assign rx_we   = tick && sample && (k_q[3:1] == 3'b111) && (mt_q != MT_WRITE);
  assign tx_idx  = (busy_q && !ph_q) ? idx_q + IDX_W'(1) : idx_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = busy_q ? sck_q : cpol;
  assign mosi    = (mt_q == MT_READ) ? 1'b0 : txsr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; done_q <= 1'b0; sck_q <= 1'b0; ph_q <= 1'b0;
      mt_q <= MT_FULL; div_q <= '0; half_m1_q <= '0; k_q <= '0;
      idx_q <= '0; last_q <= '0; txsr <= '0; rxsr <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q    <= 1'b1;
        div_q     <= '0;
        k_q       <= '0;
        idx_q     <= '0;
        sck_q     <= cpol;
        ph_q      <= cpha;
        mt_q      <= mtype;
        half_m1_q <= (DIV_W'(BASE_HALF) << code) - DIV_W'(1);
        last_q    <= nbytes - CNT_W'(1);
        txsr      <= tx_byte;
      end else if (busy_q) begin
        div_q <= tick ? '0 : div_q + DIV_W'(1);
        if (tick) begin
          sck_q <= ~sck_q;
          k_q   <= k_q + 4'd1;
          if (sample) rxsr <= rx_byte[6:0];
          else if ((ph_q && k_q == 4'd0) || (!ph_q && k_q == 4'd15)) txsr <= tx_byte;
          else txsr <= {txsr[6:0], 1'b0};
          if (k_q == 4'd15) begin
            if (last_byte) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              idx_q  <= '0;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
      end
    end
  end

  // R2
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sck));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
endmodule

// File: rtl/spi_msg_ctrl.sv
module spi_msg_ctrl
  import spimc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NCS       = 4,
  parameter int BASE_HALF = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [4:0]     reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  output logic           irq,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1;

  logic [2:0]       rate_q;
  logic             cpol_q, cpha_q, stat_q, mask_q;
  logic [7:0]       cnt_q;
  msg_type_e        mt_q;
  logic [CNT_W-1:0] tx_wptr, tail_q;
  logic [CS_W-1:0]  dev_q;

  logic             busy, eng_done, rx_we;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic [7:0]       tx_byte, rx_byte, rx_rd;
  logic             start_cmd, start_go, push_ok, clr_wr, cnt_ok;
  logic             unused_bits;

  assign unused_bits = ^reg_wdata[15:10];

  assign start_cmd = reg_wr && reg_addr == A_CMD && reg_wdata[3:0] == OP_START
                     && reg_wdata[7:4] == 4'd0;
  assign cnt_ok    = (cnt_q != 8'd0) && (cnt_q <= 8'(DEPTH));
  assign start_go  = start_cmd && cnt_ok && !busy;
  assign push_ok   = reg_wr && reg_addr == A_TXPUSH && !busy && (tx_wptr < CNT_W'(DEPTH));
  assign clr_wr    = reg_wr && reg_addr == A_ISTAT && reg_wdata[7:0] == CLR_ALL;

  spimc_bytebuf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_txbuf (
    .clk(clk), .we(push_ok), .waddr(tx_wptr[IDX_W-1:0]), .wdata(reg_wdata[7:0]),
    .raddr(tx_idx), .rdata(tx_byte));

  spimc_bytebuf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rxbuf (
    .clk(clk), .we(rx_we), .waddr(rx_idx), .wdata(rx_byte),
    .raddr(reg_addr[IDX_W-1:0]), .rdata(rx_rd));

  spimc_shifter #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .BASE_HALF(BASE_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_go), .cpol(cpol_q), .cpha(cpha_q),
    .rate(rate_q), .nbytes(cnt_q[CNT_W-1:0]), .mtype(mt_q), .tx_byte(tx_byte),
    .miso(miso), .tx_idx(tx_idx), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .busy(busy), .done(eng_done), .sck(sck), .mosi(mosi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; cnt_q <= '0; mt_q <= MT_FULL;
      tx_wptr <= '0; tail_q <= '0; dev_q <= '0; stat_q <= 1'b0; mask_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MODE) begin
        rate_q <= reg_wdata[2:0];
        cpol_q <= reg_wdata[3];
        cpha_q <= reg_wdata[4];
      end
      if (reg_wr && reg_addr == A_RATE) rate_q <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_MSG) begin
        cnt_q <= reg_wdata[7:0];
        mt_q  <= msg_type_e'(reg_wdata[9:8]);
      end
      if (reg_wr && reg_addr == A_IMASK) mask_q <= reg_wdata[0];
      if (eng_done) tx_wptr <= '0;
      else if (push_ok) tx_wptr <= tx_wptr + CNT_W'(1);
      if (start_go) begin
        dev_q  <= reg_wdata[8 +: CS_W];
        tail_q <= '0;
      end else if (rx_we) begin
        tail_q <= tail_q + CNT_W'(1);
      end
      if (eng_done) stat_q <= 1'b1;
      else if (clr_wr) stat_q <= 1'b0;
    end
  end

  assign cs_n = busy ? ~(NCS'(1) << dev_q) : '1;
  assign irq  = stat_q & mask_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) begin
      if (int'(reg_addr[3:0]) < DEPTH) reg_rdata = {8'd0, rx_rd};
    end else begin
      case (reg_addr)
        A_MODE:   reg_rdata = {11'd0, cpha_q, cpol_q, rate_q};
        A_RATE:   reg_rdata = {13'd0, rate_q};
        A_MSG:    reg_rdata = {6'd0, mt_q, cnt_q};
        A_ISTAT:  reg_rdata = {15'd0, stat_q};
        A_IMASK:  reg_rdata = {15'd0, mask_q};
        A_RXTAIL: reg_rdata = 16'(tail_q);
        default:  reg_rdata = '0;
      endcase
    end
  end

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && busy) |=> $stable(dev_q));

  // R6
  txptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tx_wptr));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !eng_done) |=> !stat_q);

  // R12
  tail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_q <= CNT_W'(DEPTH));
endmodule

// File: tb/tb_spi_msg_ctrl.sv
module tb_spi_msg_ctrl;
  import spimc_pkg::*;
  localparam int DEPTH = 8;
  localparam int NCS   = 4;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  wire  [15:0] reg_rdata;
  wire irq, sck, mosi, miso;
  wire [NCS-1:0] cs_n;

  always #10 clk = ~clk;

  spi_msg_ctrl #(.DEPTH(DEPTH), .NCS(NCS), .BASE_HALF(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int n_chk = 0, n_fail = 0, cyc = 0;

  // protocol-level slave model
  logic [7:0] s_tx [8];
  logic [7:0] s_rx [8];
  logic [6:0] s_cnt = '0;
  logic sck_d = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0;
  logic [NCS-1:0] cs_d = '1, seen_lo = '0;
  int last_edge = 0, half_meas = 0;

  initial for (int i = 0; i < 8; i++) begin s_tx[i] = 8'h00; s_rx[i] = 8'h00; end

  assign miso = s_tx[s_cnt[5:3]][3'd7 - s_cnt[2:0]];

  always @(negedge clk) begin
    cyc++;
    if (!(&cs_d) && sck != sck_d) begin
      half_meas = cyc - last_edge;
      last_edge = cyc;
      if ((sck != m_cpol) != m_cpha) begin
        s_rx[s_cnt[5:3]][3'd7 - s_cnt[2:0]] = mosi;
        s_cnt++;
      end
    end
    if ((&cs_d) && !(&cs_n)) begin s_cnt = '0; last_edge = cyc; end
    seen_lo |= ~cs_n;
    sck_d = sck;
    cs_d  = cs_n;
  end

  function automatic logic [7:0] txb(input logic [7:0] b, input int i);
    return b + 8'(i * 37);
  endfunction
  function automatic logic [7:0] sb(input logic [7:0] b, input int i);
    return b + 8'(i * 29);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [15:0] v;
    int t = 0;
    do begin rd(A_ISTAT, v); t++; end while (!v[0] && t < 20000);
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic [2:0] r);
    m_cpol = pol; m_cpha = pha;
    wr(A_MODE, {11'd0, pha, pol, r});
  endtask

  task automatic run_msg(input logic [1:0] dev, input int n, input int npush,
                         input logic [1:0] mt, input logic [7:0] tbase, input logic [7:0] sbase);
    for (int i = 0; i < 8; i++) begin s_tx[i] = sb(sbase, i); s_rx[i] = 8'h00; end
    for (int i = 0; i < npush; i++) wr(A_TXPUSH, {8'd0, txb(tbase, i)});
    wr(A_MSG, {6'd0, mt, 8'(n)});
    wr(A_ISTAT, 16'h00FF);
    seen_lo = '0;
    wr(A_CMD, {6'd0, dev, 4'h0, OP_START});
    wait_done();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 cs_n", 32'(cs_n), 32'hF);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 sck", 32'(sck), 0);
    rd(A_MODE, v);   chk("R1 mode", 32'(v), 0);
    rd(A_ISTAT, v);  chk("R1 status", 32'(v), 0);
    rd(A_RXTAIL, v); chk("R1 tail", 32'(v), 0);
  endtask

  task automatic t_modes();
    logic [15:0] v;
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0], 3'd0);
      chk("R2 idle sck", 32'(sck), 32'(m[1]));
      run_msg(2'd1, 3, 3, 2'd0, 8'h10 + 8'(m), 8'hA1 + 8'(m));
      for (int i = 0; i < 3; i++) begin
        chk("R2 mosi byte", 32'(s_rx[i]), 32'(txb(8'h10 + 8'(m), i)));
        rd(5'h10 + 5'(i), v);
        chk("R12 rx byte", 32'(v), 32'(sb(8'hA1 + 8'(m), i)));
      end
      chk("R9 cs select", 32'(seen_lo), 32'h2);
      rd(A_RXTAIL, v); chk("R12 tail full", 32'(v), 3);
    end
  endtask

  task automatic t_types();
    logic [15:0] v;
    set_mode(1'b0, 1'b0, 3'd1);
    run_msg(2'd2, 2, 2, 2'd2, 8'h3C, 8'h77);
    chk("R5 write byte0", 32'(s_rx[0]), 32'(txb(8'h3C, 0)));
    chk("R5 write byte1", 32'(s_rx[1]), 32'(txb(8'h3C, 1)));
    rd(A_RXTAIL, v); chk("R5 write tail", 32'(v), 0);
    set_mode(1'b1, 1'b0, 3'd1);
    run_msg(2'd3, 2, 2, 2'd1, 8'hFF, 8'h5B);
    chk("R5 read mosi zero", 32'({s_rx[0], s_rx[1]}), 0);
    rd(5'h11, v); chk("R5 read stored", 32'(v), 32'(sb(8'h5B, 1)));
    rd(A_RXTAIL, v); chk("R12 read tail", 32'(v), 2);
    chk("R9 cs select", 32'(seen_lo), 32'h8);
  endtask

  task automatic t_rate();
    logic [15:0] v;
    set_mode(1'b1, 1'b1, 3'd5);
    wr(A_RATE, 16'h0003);
    rd(A_MODE, v); chk("R4 rate only", 32'(v), 32'h1B);
    run_msg(2'd0, 1, 1, 2'd0, 8'h81, 8'h42);
    chk("R3 half period code3", 32'(half_meas), 8);
    chk("R2 mode3 byte", 32'(s_rx[0]), 32'(txb(8'h81, 0)));
    wr(A_RATE, 16'h0007);
    run_msg(2'd0, 1, 1, 2'd0, 8'h66, 8'h42);
    chk("R3 half period code7", 32'(half_meas), 64);
  endtask

  task automatic t_depth();
    logic [15:0] v;
    set_mode(1'b0, 1'b0, 3'd0);
    run_msg(2'd0, 8, 9, 2'd0, 8'h20, 8'h90);
    for (int i = 0; i < 8; i++) chk("R6 depth byte", 32'(s_rx[i]), 32'(txb(8'h20, i)));
    rd(A_RXTAIL, v); chk("R12 tail depth", 32'(v), 8);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    set_mode(1'b0, 1'b0, 3'd3);
    for (int i = 0; i < 8; i++) begin s_tx[i] = 8'h00; s_rx[i] = 8'h00; end
    wr(A_TXPUSH, 16'h00C1); wr(A_TXPUSH, 16'h00C2);
    wr(A_MSG, 16'h0002);
    wr(A_ISTAT, 16'h00FF);
    seen_lo = '0;
    wr(A_CMD, {6'd0, 2'd0, 4'h0, OP_START});
    wr(A_TXPUSH, 16'h005A);
    wr(A_CMD, {6'd0, 2'd2, 4'h0, OP_START});
    wait_done();
    chk("R8 busy start", 32'(seen_lo), 32'h1);
    chk("R6 byte1", 32'(s_rx[1]), 32'hC2);
    repeat (40) @(negedge clk);
    chk("R8 no late start", 32'(cs_n), 32'hF);
    run_msg(2'd0, 3, 0, 2'd0, 8'h00, 8'h00);
    chk("R6 busy push ignored", 32'(s_rx[2]), 32'(txb(8'h20, 2)));
    chk("R6 pointer reset", 32'(s_rx[0]), 32'hC1);
    rd(A_ISTAT, v); chk("R10 done set", 32'(v), 1);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    wr(A_ISTAT, 16'h00FF);
    seen_lo = '0;
    wr(A_MSG, 16'h0002);
    wr(A_CMD, {6'd0, 2'd1, 4'h1, OP_START});
    wr(A_CMD, {6'd0, 2'd1, 4'h0, 4'h2});
    wr(A_MSG, 16'h0000);
    wr(A_CMD, {6'd0, 2'd1, 4'h0, OP_START});
    wr(A_MSG, 16'h0009);
    wr(A_CMD, {6'd0, 2'd1, 4'h0, OP_START});
    repeat (40) @(negedge clk);
    chk("R7 no select", 32'(seen_lo), 0);
    rd(A_ISTAT, v); chk("R7 no done", 32'(v), 0);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    set_mode(1'b0, 1'b0, 3'd0);
    wr(A_IMASK, 16'h0000);
    run_msg(2'd1, 1, 1, 2'd0, 8'h11, 8'h22);
    chk("R10 masked irq", 32'(irq), 0);
    wr(A_IMASK, 16'h0001);
    @(negedge clk); chk("R10 irq", 32'(irq), 1);
    wr(A_ISTAT, 16'h0001);
    rd(A_ISTAT, v); chk("R11 partial no clear", 32'(v), 1);
    wr(A_ISTAT, 16'h00FF);
    rd(A_ISTAT, v); chk("R11 clear all", 32'(v), 0);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_types();
    t_rate();
    t_depth();
    t_busy();
    t_ignore();
    t_irq();
    summary();
  end
endmodule